// File: doc/BRIEF.md
# Multi-Queue Block-Counting FIFO Controller

This controller keeps eight circular sample queues that live in two shared memory banks, four queues per bank. A streaming agent (an audio DMA engine) moves samples into and out of the queues by raising a request on a queue. The controller turns each accepted request into one access to that queue's bank, at the queue's base address plus its current read or write offset. It then advances that offset modulo the queue length.

Each queue counts every sample moved through it, reads and writes together. When the count reaches the configured block size, the counter restarts. The queue's own interrupt flag is set, and the queue's block pointer moves to the address where the agent will continue. After a one-time setup through a small register write port, the controller runs without further processor help. Requests from several queues of one bank in the same cycle are served one per cycle, lowest slot first. The two banks work in parallel.

Queue q belongs to bank q/4 and holds slot q%4 in that bank. The bank memories are outside the block: each bank port gives enable, write enable, address and write data, and returns read data one cycle after a read command.

Top module: `mbfc_top`

## Requirements
- R1: After reset, every flag and pulse output is 0: acc_ack, rd_valid, irq, err and mem_en. Every blk_ptr is also 0.
- R2: A configuration write goes to queue cfg_queue. cfg_sel selects the field: 0 is the base address, 1 the length in words, 2 the block size in samples, and 3 the enable (bit 0 of cfg_data). Writing enable=1 clears both offsets and the sample count, and sets blk_ptr to the base.
- R3: An enabled queue whose request is seen at a rising edge has acc_ack high for the following cycle. In that same cycle its bank's port shows mem_en=1, mem_we equal to acc_wr, and mem_addr equal to base plus the write offset. For a write, mem_wdata carries the queue's data.
- R4: An accepted read uses address base plus the read offset. One cycle after the ack, rd_valid for that queue is high for one cycle, and the bank's rd_data holds the word stored at that address.
- R5: Read and write offsets advance independently by one per accepted access. Each returns to 0 after reaching length-1.
- R6: Accepted reads and writes both count toward a queue's block. The access that completes a block sets irq for that queue in the same cycle as its ack. That access also sets blk_ptr to base plus the offset after the access.
- R7: irq is sticky until a cycle with the queue's irq_clr bit high. If a block completes in the same cycle as a clear, irq stays set.
- R8: A request to a disabled queue is acknowledged without any bank access and without moving that queue's pointers. It sets the queue's err flag, which holds until err_clr is pulsed.
- R9: When several enabled queues of one bank request in the same cycle, only the lowest slot is served. The others wait until later edges. Each bank serves one queue per cycle independently of the other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_queue | input | 3 | Queue index for the configuration write |
| cfg_sel | input | 2 | Field select: 0 base, 1 length, 2 block size, 3 enable |
| cfg_data | input | 11 | Configuration value |
| irq_clr | input | 8 | Per-queue interrupt clear, write 1 to clear |
| err_clr | input | 8 | Per-queue error clear |
| acc_req | input | 8 | Per-queue access request, held for one access per cycle |
| acc_wr | input | 8 | Per-queue direction, 1 = write into the queue |
| acc_wdata | input | 192 | Per-queue write data, 24 bits per queue |
| acc_ack | output | 8 | Per-queue acceptance pulse |
| rd_valid | output | 8 | Per-queue read data valid |
| rd_data | output | 48 | Read data of each bank, 24 bits per bank |
| mem_en | output | 2 | Per-bank memory enable |
| mem_we | output | 2 | Per-bank memory write enable |
| mem_addr | output | 20 | Per-bank memory address, 10 bits per bank |
| mem_wdata | output | 48 | Per-bank memory write data |
| mem_rdata | input | 48 | Per-bank memory read data |
| irq | output | 8 | Per-queue sticky block interrupt |
| err | output | 8 | Per-queue sticky disabled-access error |
| blk_ptr | output | 80 | Per-queue block pointer, 10 bits per queue |

## Verification
The ack, the bank command, the irq update and blk_ptr all follow from the rising edge that accepts a request. The bench therefore checks them at the falling edge right after that edge. Read data arrives one edge later, because the bank memory registers it, so rd_valid and rd_data are sampled one falling edge later again. Each scenario task drives its inputs at a falling edge and steps exactly one or two falling edges before sampling. The priority test holds a losing request and expects its ack one cycle after the winner's.

// File: rtl/mbfc_pkg.sv
package mbfc_pkg;
  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_LEN   = 2'd1,
    FLD_BSIZE = 2'd2,
    FLD_EN    = 2'd3
  } cfg_field_e;
endpackage

// File: rtl/mbfc_queue.sv
module mbfc_queue
  import mbfc_pkg::*;
#(
  parameter int AW = 10,
  parameter int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [LW-1:0] cfg_data,
  input  logic          req,
  input  logic          req_wr,
  input  logic          take,
  input  logic          irq_clr,
  input  logic          err_clr,
  output logic          en,
  output logic [AW-1:0] addr,
  output logic          irq,
  output logic          err,
  output logic [AW-1:0] blk_ptr
);
  logic [AW-1:0] base, wptr, rptr;
  logic [LW-1:0] len, bsize, cnt;
  logic [AW-1:0] off, off_next;
  logic          blk_done;

  always_comb begin
    off  = req_wr ? wptr : rptr;
    addr = base + off;
    if ({1'b0, off} + LW'(1) >= len) off_next = '0;
    else                             off_next = off + AW'(1);
    blk_done = (cnt + LW'(1) >= bsize);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0; len <= '0; bsize <= '0; en <= 1'b0;
      wptr <= '0; rptr <= '0; cnt <= '0; blk_ptr <= '0;
    end else if (cfg_we) begin
      case (cfg_field_e'(cfg_sel))
        FLD_BASE:  base  <= cfg_data[AW-1:0];
        FLD_LEN:   len   <= cfg_data;
        FLD_BSIZE: bsize <= cfg_data;
        FLD_EN: begin
          en <= cfg_data[0];
          if (cfg_data[0]) begin
            wptr <= '0; rptr <= '0; cnt <= '0; blk_ptr <= base;
          end
        end
        default: ;
      endcase
    end else if (take) begin
      if (req_wr) wptr <= off_next;
      else        rptr <= off_next;
      if (blk_done) begin
        cnt     <= '0;
        blk_ptr <= base + off_next;
      end else begin
        cnt <= cnt + LW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      err <= 1'b0;
    end else begin
      if (take && blk_done && !cfg_we) irq <= 1'b1;
      else if (irq_clr)                irq <= 1'b0;
      if (req && !en)                  err <= 1'b1;
      else if (err_clr)                err <= 1'b0;
    end
  end

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(take));
  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(req && !en));
  p_idle_ptr_r5: assert property (@(posedge clk) disable iff (rst)
    (!take && !cfg_we) |=> ($stable(wptr) && $stable(rptr)));
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (irq && irq_clr && !take && !cfg_we) |=> !irq);
endmodule

// File: rtl/mbfc_arb.sv
module mbfc_arb #(
  parameter int N  = 4,
  parameter int AW = 10,
  parameter int DW = 24,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req,
  input  logic [N-1:0]    wr,
  input  logic [N*AW-1:0] addr,
  input  logic [N*DW-1:0] wdata,
  output logic [N-1:0]    gnt,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata
);
  logic [SW-1:0] sel;
  logic          found;

  always_comb begin
    gnt   = '0;
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        sel    = SW'(i);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en <= 1'b0;
      mem_we <= 1'b0;
    end else begin
      mem_en <= found;
      mem_we <= found && wr[sel];
    end
  end

  always_ff @(posedge clk) begin
    mem_addr  <= addr[sel*AW +: AW];
    mem_wdata <= wdata[sel*DW +: DW];
  end

  p_one_grant_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  p_cmd_source_r3: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> $past(|req));
  p_cmd_issued_r3: assert property (@(posedge clk) disable iff (rst)
    (|req) |=> mem_en);
endmodule

// File: rtl/mbfc_top.sv
module mbfc_top #(
  parameter int NB  = 2,
  parameter int QPB = 4,
  parameter int AW  = 10,
  parameter int DW  = 24,
  localparam int NQ = NB * QPB,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [QW-1:0]    cfg_queue,
  input  logic [1:0]       cfg_sel,
  input  logic [LW-1:0]    cfg_data,
  input  logic [NQ-1:0]    irq_clr,
  input  logic [NQ-1:0]    err_clr,
  input  logic [NQ-1:0]    acc_req,
  input  logic [NQ-1:0]    acc_wr,
  input  logic [NQ*DW-1:0] acc_wdata,
  output logic [NQ-1:0]    acc_ack,
  output logic [NQ-1:0]    rd_valid,
  output logic [NB*DW-1:0] rd_data,
  output logic [NB-1:0]    mem_en,
  output logic [NB-1:0]    mem_we,
  output logic [NB*AW-1:0] mem_addr,
  output logic [NB*DW-1:0] mem_wdata,
  input  logic [NB*DW-1:0] mem_rdata,
  output logic [NQ-1:0]    irq,
  output logic [NQ-1:0]    err,
  output logic [NQ*AW-1:0] blk_ptr
);
  logic [NQ-1:0]    en_v, gnt_v, rd_pend;
  logic [NQ*AW-1:0] addr_v;

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    mbfc_queue #(.AW(AW), .LW(LW)) u_queue (
      .clk     (clk),
      .rst     (rst),
      .cfg_we  (cfg_we && (cfg_queue == QW'(q))),
      .cfg_sel (cfg_sel),
      .cfg_data(cfg_data),
      .req     (acc_req[q]),
      .req_wr  (acc_wr[q]),
      .take    (gnt_v[q]),
      .irq_clr (irq_clr[q]),
      .err_clr (err_clr[q]),
      .en      (en_v[q]),
      .addr    (addr_v[q*AW +: AW]),
      .irq     (irq[q]),
      .err     (err[q]),
      .blk_ptr (blk_ptr[q*AW +: AW])
    );
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    mbfc_arb #(.N(QPB), .AW(AW), .DW(DW)) u_arb (
      .clk      (clk),
      .rst      (rst),
      .req      (acc_req[b*QPB +: QPB] & en_v[b*QPB +: QPB]),
      .wr       (acc_wr[b*QPB +: QPB]),
      .addr     (addr_v[b*QPB*AW +: QPB*AW]),
      .wdata    (acc_wdata[b*QPB*DW +: QPB*DW]),
      .gnt      (gnt_v[b*QPB +: QPB]),
      .mem_en   (mem_en[b]),
      .mem_we   (mem_we[b]),
      .mem_addr (mem_addr[b*AW +: AW]),
      .mem_wdata(mem_wdata[b*DW +: DW])
    );
  end

  assign rd_data = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_ack  <= '0;
      rd_pend  <= '0;
      rd_valid <= '0;
    end else begin
      acc_ack  <= gnt_v | (acc_req & ~en_v);
      rd_pend  <= gnt_v & ~acc_wr;
      rd_valid <= rd_pend;
    end
  end

  p_ack_source_r3: assert property (@(posedge clk) disable iff (rst)
    (|acc_ack) |-> $past(|acc_req));
  p_rd_after_ack_r4: assert property (@(posedge clk) disable iff (rst)
    (|rd_valid) |-> $past(|acc_ack));
endmodule

// File: tb/mbfc_top_test.sv
module mbfc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2, QPB = 4, AW = 10, DW = 24;
  localparam int NQ = NB * QPB;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_queue = '0;
  logic [1:0] cfg_sel = '0;
  logic [AW:0] cfg_data = '0;
  logic [NQ-1:0] irq_clr = '0, err_clr = '0, acc_req = '0, acc_wr = '0;
  logic [NQ*DW-1:0] acc_wdata = '0;
  logic [NQ-1:0] acc_ack, rd_valid, irq, err;
  logic [NB*DW-1:0] rd_data, mem_wdata, mem_rdata;
  logic [NB-1:0] mem_en, mem_we;
  logic [NB*AW-1:0] mem_addr;
  logic [NQ*AW-1:0] blk_ptr;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbfc_top uut (.*);

  logic [DW-1:0] ram0 [2**AW];
  logic [DW-1:0] ram1 [2**AW];
  always @(posedge clk) begin
    if (mem_en[0]) begin
      if (mem_we[0]) ram0[mem_addr[0 +: AW]] <= mem_wdata[0 +: DW];
      mem_rdata[0 +: DW] <= ram0[mem_addr[0 +: AW]];
    end
    if (mem_en[1]) begin
      if (mem_we[1]) ram1[mem_addr[AW +: AW]] <= mem_wdata[DW +: DW];
      mem_rdata[DW +: DW] <= ram1[mem_addr[AW +: AW]];
    end
  end

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cfg(input int q, input int sel, input int val);
    cfg_we = 1'b1; cfg_queue = 3'(q); cfg_sel = 2'(sel); cfg_data = (AW+1)'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int q, input int base, input int len, input int bs);
    cfg(q, 0, base); cfg(q, 1, len); cfg(q, 2, bs); cfg(q, 3, 1);
  endtask

  // one access; checks ack and bank command (R3/R4), read data a cycle later
  task automatic access(input int q, input bit wr, input int d, input int exp_addr,
                        input int exp_rd, input bit clr);
    int b = q / QPB;
    acc_req[q] = 1'b1; acc_wr[q] = wr; acc_wdata[q*DW +: DW] = DW'(d);
    irq_clr[q] = clr;
    @(negedge clk);
    acc_req[q] = 1'b0; irq_clr[q] = 1'b0;
    check(acc_ack[q] == 1'b1, "R3 ack", acc_ack[q], 1);
    check(mem_en[b] && mem_we[b] == wr, "R3 bank cmd", {mem_en[b], mem_we[b]}, {1'b1, wr});
    check(mem_addr[b*AW +: AW] == AW'(exp_addr), "R5 address", mem_addr[b*AW +: AW], exp_addr);
    if (wr) check(mem_wdata[b*DW +: DW] == DW'(d), "R3 wdata", mem_wdata[b*DW +: DW], d);
    else begin
      @(negedge clk);
      check(rd_valid[q] == 1'b1, "R4 rd_valid", rd_valid[q], 1);
      check(rd_data[b*DW +: DW] == DW'(exp_rd), "R4 rd_data", rd_data[b*DW +: DW], exp_rd);
    end
  endtask

  task automatic t_reset;
    check(acc_ack == 0 && rd_valid == 0 && mem_en == 0, "R1 pulses", {acc_ack, rd_valid}, 0);
    check(irq == 0 && err == 0, "R1 flags", {irq, err}, 0);
    check(blk_ptr == 0, "R1 blk_ptr", blk_ptr, 0);
  endtask

  task automatic t_stream;
    setup(0, 100, 4, 3);
    check(blk_ptr[0 +: AW] == 100, "R2 blk_ptr at enable", blk_ptr[0 +: AW], 100);
    access(0, 1, 11, 100, 0, 0);
    access(0, 1, 22, 101, 0, 0);
    check(irq[0] == 1'b0, "R6 no irq mid-block", irq[0], 0);
    access(0, 1, 33, 102, 0, 0);
    check(irq[0] == 1'b1, "R6 irq on block end", irq[0], 1);
    check(blk_ptr[0 +: AW] == 103, "R6 blk_ptr", blk_ptr[0 +: AW], 103);
    @(negedge clk);
    check(irq[0] == 1'b1, "R7 sticky", irq[0], 1);
    irq_clr[0] = 1'b1; @(negedge clk); irq_clr[0] = 1'b0;
    check(irq[0] == 1'b0, "R7 cleared", irq[0], 0);
    access(0, 1, 44, 103, 0, 0);
    access(0, 1, 55, 100, 0, 0);   // R5 write wrap
    check(irq[0] == 1'b0, "R6 count restarted", irq[0], 0);
    access(0, 0, 0, 100, 55, 0);   // read offset independent, R5
    check(irq[0] == 1'b1, "R6 read counts", irq[0], 1);
    check(blk_ptr[0 +: AW] == 101, "R6 blk_ptr after read", blk_ptr[0 +: AW], 101);
    irq_clr[0] = 1'b1; @(negedge clk); irq_clr[0] = 1'b0;
    access(0, 0, 0, 101, 22, 0);
    access(0, 0, 0, 102, 33, 0);
    access(0, 0, 0, 103, 44, 1);   // completion with clear in same cycle
    check(irq[0] == 1'b1, "R7 set wins over clear", irq[0], 1);
    access(0, 0, 0, 100, 55, 0);   // read wrap
  endtask

  task automatic t_disabled;
    acc_req[5] = 1'b1; acc_wr[5] = 1'b1;
    @(negedge clk);
    acc_req[5] = 1'b0;
    check(acc_ack[5] == 1'b1, "R8 ack", acc_ack[5], 1);
    check(mem_en[1] == 1'b0, "R8 no bank access", mem_en[1], 0);
    check(err[5] == 1'b1, "R8 err set", err[5], 1);
    check(blk_ptr[5*AW +: AW] == 0, "R8 pointer kept", blk_ptr[5*AW +: AW], 0);
    @(negedge clk);
    check(err[5] == 1'b1, "R8 err sticky", err[5], 1);
    err_clr[5] = 1'b1; @(negedge clk); err_clr[5] = 1'b0;
    check(err[5] == 1'b0, "R8 err cleared", err[5], 0);
  endtask

  task automatic t_priority;
    setup(1, 50, 8, 8);
    setup(4, 200, 8, 8);
    setup(6, 300, 8, 8);
    acc_req = 8'b0101_0010; acc_wr = 8'b0101_0010;
    acc_wdata[1*DW +: DW] = 24'd1; acc_wdata[4*DW +: DW] = 24'd4; acc_wdata[6*DW +: DW] = 24'd6;
    @(negedge clk);
    acc_req = 8'b0100_0000;
    check(acc_ack == 8'b0001_0010, "R9 winners", acc_ack, 8'b0001_0010);
    check(mem_addr[AW +: AW] == 200, "R9 bank1 slot0", mem_addr[AW +: AW], 200);
    check(mem_addr[0 +: AW] == 50, "R9 bank0 parallel", mem_addr[0 +: AW], 50);
    @(negedge clk);
    acc_req = '0;
    check(acc_ack == 8'b0100_0000, "R9 loser served next", acc_ack, 8'b0100_0000);
    check(mem_addr[AW +: AW] == 300 && mem_wdata[DW +: DW] == 6, "R9 loser cmd",
          mem_addr[AW +: AW], 300);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stream();
    t_disabled();
    t_priority();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule